// File: doc/BRIEF.md
# Watermark Write Drain Arbiter

This block sits ahead of a memory command issuer whose single data bus carries either read or write traffic, never both at once. Reads arrive on one valid/ready stream and are passed on in arrival order. Writes arrive on a second stream and are parked in a FIFO. The block emits a single command stream, with each command tagged read or write.

In normal operation reads have the bus. Parked writes go out in a batch only when the FIFO fill reaches a high watermark. The batch then continues back to back until the fill has fallen to a low watermark, and after that reads get the bus again. When no read is pending, parked writes may go out early. Every reversal of bus direction is followed by a fixed number of dead cycles before a command in the new direction may go out. Batching writes between two fill levels means that this penalty is paid once per batch and not once per write.

Top module: `wm_drain_arb`

## Requirements
- R1: While reset is held, and with no inputs active, `cmd_valid_o` and `rd_ready_o` are 0 and `wr_ready_o` is 1. The bus starts in the read direction, so a read presented in the first cycle after reset is accepted in that same cycle.
- R2: While a read is pending and no drain is in progress, no write is issued. A drain is in progress from the cycle the fill reaches `HI_WM` until the fill equals `LO_WM`.
- R3: While the fill is at or above `HI_WM`, or a drain is in progress, no read is issued, even if reads are pending.
- R4: When a drain starts from a fill of exactly `HI_WM` and no further writes arrive, exactly `HI_WM - LO_WM` writes issue before reads resume, and the fill then stays at `LO_WM`.
- R5: When no read is pending and the FIFO is not empty, writes are issued without waiting for the high watermark, so the FIFO empties.
- R6: Between two accepted commands of opposite direction, at least `TURN_CYC` cycles pass with no accepted command. This includes the first write after reset.
- R7: `wr_ready_o` is 0 exactly when the FIFO holds `WBUF_DEPTH` entries. A write is accepted when `wr_valid_i` and `wr_ready_o` are both 1, and the fill never exceeds `WBUF_DEPTH`.
- R8: Writes issue in acceptance order. On a write command, `cmd_is_wr_o` is 1 and `cmd_data_o` carries the value taken from `wr_data_i`.
- R9: Reads issue in arrival order. On a read command, `cmd_is_wr_o` is 0 and `cmd_data_o` equals `rd_data_i`. `rd_ready_o` is 1 exactly in the cycles where a read command is valid and `cmd_ready_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_valid_i | input | 1 | Read request present |
| rd_ready_o | output | 1 | Read request taken this cycle |
| rd_data_i | input | DATA_W | Read request payload |
| wr_valid_i | input | 1 | Write request present |
| wr_ready_o | output | 1 | Write FIFO has room |
| wr_data_i | input | DATA_W | Write request payload |
| cmd_valid_o | output | 1 | Command present |
| cmd_ready_i | input | 1 | Issuer takes command |
| cmd_is_wr_o | output | 1 | 1 = write command, 0 = read command |
| cmd_data_o | output | DATA_W | Command payload |

## Verification
A read passes through combinationally and is valid in the same cycle as its request. A write becomes eligible one clock after it is accepted. After a direction change, the first command in the new direction can appear no sooner than `TURN_CYC + 1` cycles after the last command in the old direction. The bench drives inputs on the falling edge and samples one time unit later, which is still before the rising edge at which the handshakes complete. It updates its own model of fill level, drain state, FIFO order and idle gap at that sample point. Each check is therefore made against the state that is due in that exact cycle. Directed phases cover the watermark burst, early drain and a full FIFO. Eight density sweeps vary read, write and ready rates.

// File: rtl/wm_arb_pkg.sv
package wm_arb_pkg;
  typedef enum logic {
    DIR_RD = 1'b0,
    DIR_WR = 1'b1
  } bus_dir_e;
endpackage

// File: rtl/wm_wbuf.sv
module wm_wbuf #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] dout_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              full_o,
  output logic              empty_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wp_q, rp_q;
  logic [CNT_W-1:0]  cnt_q;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= ptr_inc(wp_q);
      if (pop_i)  rp_q <= ptr_inc(rp_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wp_q] <= din_i;
  end

  assign dout_o  = mem_q[rp_q];
  assign cnt_o   = cnt_q;
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
endmodule

// File: rtl/wm_drain_ctl.sv
module wm_drain_ctl #(
  parameter int CNT_W = 4,
  parameter int HI_WM = 6,
  parameter int LO_WM = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             rd_pend_i,
  output logic             want_wr_o,
  output logic             drain_o
);
  logic drain_q, drain_eff;

  // hysteresis: enter at HI, leave once fill is back at LO
  assign drain_eff = drain_q ? (cnt_i > CNT_W'(LO_WM)) : (cnt_i >= CNT_W'(HI_WM));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) drain_q <= 1'b0;
    else         drain_q <= drain_eff;
  end

  assign want_wr_o = drain_eff || (!rd_pend_i && (cnt_i != '0));
  assign drain_o   = drain_eff;
endmodule

// File: rtl/wm_turn_ctl.sv
module wm_turn_ctl
  import wm_arb_pkg::*;
#(
  parameter int TURN_CYC = 3
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     pend_i,
  input  bus_dir_e want_dir_i,
  output bus_dir_e dir_o,
  output logic     go_o
);
  localparam int TURN_W = (TURN_CYC < 1) ? 1 : $clog2(TURN_CYC + 1);

  bus_dir_e          dir_q;
  logic [TURN_W-1:0] turn_q;

  // once a reversal starts it runs to completion
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= DIR_RD;
      turn_q <= '0;
    end else if (turn_q != '0) begin
      turn_q <= turn_q - 1'b1;
    end else if (pend_i && (want_dir_i != dir_q)) begin
      dir_q  <= want_dir_i;
      turn_q <= TURN_W'(TURN_CYC);
    end
  end

  assign dir_o = dir_q;
  assign go_o  = pend_i && (turn_q == '0) && (want_dir_i == dir_q);
endmodule

// File: rtl/wm_drain_arb.sv
module wm_drain_arb
  import wm_arb_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int WBUF_DEPTH = 8,
  parameter int HI_WM      = 6,
  parameter int LO_WM      = 2,
  parameter int TURN_CYC   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_valid_i,
  output logic              rd_ready_o,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              wr_valid_i,
  output logic              wr_ready_o,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic              cmd_is_wr_o,
  output logic [DATA_W-1:0] cmd_data_o
);
  localparam int CNT_W = $clog2(WBUF_DEPTH + 1);

  logic              push, pop, full, empty, want_wr, drain, pend, go;
  logic [CNT_W-1:0]  wcnt;
  logic [DATA_W-1:0] wdata;
  bus_dir_e          dir, want_dir;

  wm_wbuf #(
    .DATA_W(DATA_W),
    .DEPTH (WBUF_DEPTH),
    .CNT_W (CNT_W)
  ) u_wbuf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (push),
    .din_i  (wr_data_i),
    .pop_i  (pop),
    .dout_o (wdata),
    .cnt_o  (wcnt),
    .full_o (full),
    .empty_o(empty)
  );

  wm_drain_ctl #(
    .CNT_W(CNT_W),
    .HI_WM(HI_WM),
    .LO_WM(LO_WM)
  ) u_drain (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cnt_i    (wcnt),
    .rd_pend_i(rd_valid_i),
    .want_wr_o(want_wr),
    .drain_o  (drain)
  );

  assign pend     = rd_valid_i || !empty;
  assign want_dir = want_wr ? DIR_WR : DIR_RD;

  wm_turn_ctl #(
    .TURN_CYC(TURN_CYC)
  ) u_turn (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pend_i    (pend),
    .want_dir_i(want_dir),
    .dir_o     (dir),
    .go_o      (go)
  );

  assign wr_ready_o  = !full;
  assign push        = wr_valid_i && !full;
  assign cmd_valid_o = go && ((dir == DIR_WR) ? !empty : rd_valid_i);
  assign cmd_is_wr_o = (dir == DIR_WR);
  assign cmd_data_o  = (dir == DIR_WR) ? wdata : rd_data_i;
  assign pop         = cmd_valid_o && cmd_ready_i && (dir == DIR_WR);
  assign rd_ready_o  = cmd_valid_o && cmd_ready_i && (dir == DIR_RD);
endmodule

// File: rtl/wm_drain_arb_chk.sv
module wm_drain_arb_chk #(
  parameter int DEPTH    = 8,
  parameter int HI_WM    = 6,
  parameter int LO_WM    = 2,
  parameter int TURN_CYC = 3,
  parameter int CNT_W    = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_valid_i,
  input logic             cmd_ready_i,
  input logic             cmd_is_wr_i,
  input logic             rd_valid_i,
  input logic             rd_ready_i,
  input logic             wr_ready_i,
  input logic [CNT_W-1:0] wcnt_i
);
  logic        fire, last_wr_q;
  logic [15:0] idle_q;

  assign fire = cmd_valid_i && cmd_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_wr_q <= 1'b0;
      idle_q    <= '0;
    end else if (fire) begin
      last_wr_q <= cmd_is_wr_i;
      idle_q    <= '0;
    end else if (idle_q != 16'hffff) begin
      idle_q <= idle_q + 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wcnt_i <= CNT_W'(DEPTH)); // R7
  AST_FULL_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wcnt_i == CNT_W'(DEPTH)) |-> !wr_ready_i); // R7
  AST_HOLD_WRITES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && cmd_is_wr_i && rd_valid_i) |-> (wcnt_i > CNT_W'(LO_WM))); // R2
  AST_DRAIN_BLOCKS_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !cmd_is_wr_i) |-> (wcnt_i < CNT_W'(HI_WM))); // R3
  AST_TURN_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && (cmd_is_wr_i != last_wr_q)) |-> (idle_q >= 16'(TURN_CYC))); // R6
  AST_RD_HANDSHAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ready_i |-> (rd_valid_i && cmd_ready_i && !cmd_is_wr_i)); // R9
endmodule

bind wm_drain_arb wm_drain_arb_chk #(
  .DEPTH   (WBUF_DEPTH),
  .HI_WM   (HI_WM),
  .LO_WM   (LO_WM),
  .TURN_CYC(TURN_CYC),
  .CNT_W   (CNT_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmd_valid_i(cmd_valid_o),
  .cmd_ready_i(cmd_ready_i),
  .cmd_is_wr_i(cmd_is_wr_o),
  .rd_valid_i (rd_valid_i),
  .rd_ready_i (rd_ready_o),
  .wr_ready_i (wr_ready_o),
  .wcnt_i     (wcnt)
);

// File: tb/sim_wm_drain_arb.sv
`timescale 1ns/1ps
module sim_wm_drain_arb;
  localparam int DW = 8, DEPTH = 8, HI = 6, LO = 2, TURN = 3;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic rd_valid_i = 1'b0, wr_valid_i = 1'b0, cmd_ready_i = 1'b0;
  logic [DW-1:0] rd_data_i = '0, wr_data_i = '0;
  logic rd_ready_o, wr_ready_o, cmd_valid_o, cmd_is_wr_o;
  logic [DW-1:0] cmd_data_o;

  always #10 clk_i = ~clk_i;

  wm_drain_arb #(.DATA_W(DW), .WBUF_DEPTH(DEPTH), .HI_WM(HI), .LO_WM(LO), .TURN_CYC(TURN)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .rd_valid_i(rd_valid_i), .rd_ready_o(rd_ready_o), .rd_data_i(rd_data_i),
    .wr_valid_i(wr_valid_i), .wr_ready_o(wr_ready_o), .wr_data_i(wr_data_i),
    .cmd_valid_o(cmd_valid_o), .cmd_ready_i(cmd_ready_i),
    .cmd_is_wr_o(cmd_is_wr_o), .cmd_data_o(cmd_data_o)
  );

  int tests = 0, fails = 0;
  bit done = 0;
  int cnt_m = 0, idle = 0, rd_seq = 0, wr_seq = 0, wh = 0, wt = 0;
  int wr_fires = 0, rd_fires = 0, switches = 0, accepted = 0;
  bit drain_m = 0, last_wr = 0, rd_v = 0, wr_v = 0, last_rfire = 0;
  logic [DW-1:0] wq [256];
  logic [15:0] lf = 16'hace1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input bit want_rd, input bit want_wr, input bit rdy);
    bit fire, wfire, rfire, eff, acc;
    @(negedge clk_i);
    if (!rd_v && want_rd) rd_v = 1;
    if (!wr_v && want_wr) wr_v = 1;
    rd_valid_i = rd_v; rd_data_i = rd_seq[DW-1:0];
    wr_valid_i = wr_v; wr_data_i = wr_seq[DW-1:0];
    cmd_ready_i = rdy;
    #1;
    fire  = cmd_valid_o && rdy;
    wfire = fire && cmd_is_wr_o;
    rfire = fire && !cmd_is_wr_o;
    last_rfire = rfire;
    eff = drain_m ? (cnt_m > LO) : (cnt_m >= HI);
    chk(wr_ready_o == (cnt_m < DEPTH), "R7 wr_ready", wr_ready_o, cnt_m < DEPTH);
    chk(rd_ready_o == rfire, "R9 rd_ready", rd_ready_o, rfire);
    if (wfire) begin
      chk(!(rd_v && !eff), "R2 write while reads pending", 1, 0);
      chk(cnt_m > 0, "R8 write from empty fifo", cnt_m, 1);
      chk(cmd_data_o == wq[wh], "R8 write order", cmd_data_o, wq[wh]);
    end
    if (rfire) begin
      chk(!eff, "R3 read during drain", cnt_m, LO);
      chk(cmd_data_o == rd_seq[DW-1:0], "R9 read data", cmd_data_o, rd_seq[DW-1:0]);
    end
    if (fire && (cmd_is_wr_o != last_wr)) begin
      chk(idle >= TURN, "R6 turnaround gap", idle, TURN);
      switches++;
    end
    if (fire) begin last_wr = cmd_is_wr_o; idle = 0; end
    else idle++;
    drain_m = eff;
    acc = wr_v && wr_ready_o;
    if (acc) begin
      wq[wt] = wr_seq[DW-1:0]; wt = (wt + 1) % 256; wr_seq++; wr_v = 0; cnt_m++; accepted++;
    end
    if (wfire) begin wh = (wh + 1) % 256; cnt_m--; wr_fires++; end
    if (rfire) begin rd_seq++; rd_v = 0; rd_fires++; end
  endtask

  initial begin
    int wf0, rf0;
    repeat (3) @(negedge clk_i);
    #1;
    chk(cmd_valid_o == 0, "R1 reset cmd_valid", cmd_valid_o, 0);
    chk(rd_ready_o == 0, "R1 reset rd_ready", rd_ready_o, 0);
    chk(wr_ready_o == 1, "R1 reset wr_ready", wr_ready_o, 1);
    rst_ni = 1'b1;
    cyc(1, 0, 1);
    chk(last_rfire, "R1 read in first cycle", last_rfire, 1);

    // watermark burst: reads stream, exactly HI writes arrive
    wf0 = wr_fires;
    while (accepted < HI) cyc(1, 1, 1);
    chk(wr_fires == wf0, "R2 writes held below HI", wr_fires - wf0, 0);
    rf0 = rd_fires;
    repeat (60) cyc(1, 0, 1);
    chk(wr_fires - wf0 == HI - LO, "R4 burst length", wr_fires - wf0, HI - LO);
    chk(cnt_m == LO, "R4 fill after drain", cnt_m, LO);
    chk(rd_fires > rf0, "R4 reads resume", rd_fires - rf0, 1);

    // early drain without reads
    repeat (40) cyc(0, 0, 1);
    chk(cnt_m == 0, "R5 early drain empties", cnt_m, 0);

    // full FIFO with issuer stalled
    wf0 = accepted;
    repeat (DEPTH + 6) cyc(0, 1, 0);
    chk(accepted - wf0 == DEPTH, "R7 accepts up to depth", accepted - wf0, DEPTH);
    chk(wr_ready_o == 0, "R7 full stall", wr_ready_o, 0);
    repeat (40) cyc(0, 0, 1);
    chk(cnt_m == 0 && !wr_v, "R5 drain after full", cnt_m, 0);

    // density sweeps
    for (int p = 0; p < 8; p++) begin
      for (int c = 0; c < 300; c++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        cyc(int'(lf[3:0]) < 2 + 2 * p, int'(lf[7:4]) < 16 - 2 * p, int'(lf[11:8]) >= p);
      end
    end
    repeat (80) cyc(0, 0, 1);
    chk(cnt_m == 0, "R5 final empty", cnt_m, 0);
    chk(switches > 10, "R6 reversals exercised", switches, 11);
    chk(wr_fires == accepted, "R8 all writes issued", wr_fires, accepted);

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule